// File: doc/BRIEF.md
# 64b/67b Word Alignment Decoder

This block sits behind a deserializer that hands over 67-bit parallel words whose boundaries are rotated by an unknown, fixed number of bits. Every correctly framed 67-bit word carries a two-bit header that always changes value between its two bits. The block finds where that header sits. For each incoming word it forms a mask of the places where adjacent bits differ. It keeps only those places that show a change in every word seen so far. Once a single candidate has held for a run of words, it declares word lock.

While locked, the block joins the previous and the current raw word and cuts out the aligned 67-bit word. It checks the header and undoes the polarity inversion flagged by the inversion bit. It then delivers the 64-bit payload with a control flag and a header-error flag. Lock is held as long as header errors stay within a budget per fixed window of words. Once the budget is exceeded, the search starts again from scratch.

Both data sides are valid/ready streams. Back-pressure on the output stalls the input: the block holds one output word. It takes a new input word only in a cycle where that output slot is empty or being drained. Words taken while unlocked are consumed without producing output.

Top module: `word_align_dec`

## Requirements
- R1: After reset, `lock` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: When the header keeps a fixed position, `lock` rises right after the 64th word accepted since reset or since lock was lost, and not earlier. Adjacent-bit positions are ranked cyclically: the first bit of a word follows the last bit of the word before it.
- R3: A stream in which no adjacent-bit change recurs in every word never reaches lock and produces no output.
- R4: No output word is produced while unlocked. Each word accepted while locked produces exactly one output word, in order.
- R5: For any rotation 0..66, the output for received word k is aligned word k. Received word k begins s bits into aligned word k, counting from its first transmitted bit (bit 66).
- R6: In an aligned word, bits 66:65 are the header and bit 64 is the inversion bit. Header `10` gives `out_ctrl`=1, and header `01` gives `out_ctrl`=0. When bit 64 is 1, `out_data` is the bitwise inverse of bits 63:0; otherwise it equals them.
- R7: `out_hdr_err` is 1 exactly for output words whose bits 66 and 65 are equal.
- R8: Header errors are counted in windows of 64 locked words, starting at the first word after lock. Up to 16 errors in one window keep lock, and the count restarts at each window boundary.
- R9: The 17th header error within one window clears `lock` on that word. That word is still output. A fresh search then needs another 64 words to relock.
- R10: `in_ready` equals `out_ready` or not `out_valid`. While `out_valid` is 1 and `out_ready` is 0, the output word stays unchanged and no input is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Raw word available |
| in_ready | output | 1 | Raw word taken this cycle when `in_valid` is 1 |
| in_word | input | 67 | Raw deserialized word, bit 66 received first |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 64 | Payload with polarity restored |
| out_ctrl | output | 1 | 1 for a control word, 0 for a data word |
| out_hdr_err | output | 1 | Header of this word was invalid |
| lock | output | 1 | Word lock held |

## Verification
The checker assumes that the bit rotation stays constant from reset until the next reset. It also assumes that the inputs carry no unknown values after reset is released. The bench applies a fresh reset before every change of rotation. It drives every input on the falling clock edge, so the inputs are settled at each rising edge. Headers are corrupted only on words that follow lock, at window positions chosen ahead of time. This keeps the lock-count property tied to stretches of well-framed words.

// File: rtl/align_pkg.sv
package align_pkg;
  localparam int WORD_W = 67;
  localparam int PAY_W  = 64;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int INV_BIT = 64;
  localparam int HDR_HI  = 66;
  localparam int HDR_LO  = 65;
  localparam logic [1:0] HDR_CTRL = 2'b10;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PAY_W-1:0]  pay_t;
  typedef logic [POS_W-1:0]  pos_t;
endpackage

// File: rtl/align_trans_mask.sv
module align_trans_mask
  import align_pkg::*;
(
  input  word_t cur,
  input  logic  prev_lsb,
  input  logic  prev_ok,
  output word_t mask
);
  // Bit i marks a change between cur[i] and the bit sent just before it.
  for (genvar i = 0; i < WORD_W - 1; i++) begin : g_pair
    assign mask[i] = cur[i] ^ cur[i+1];
  end
  // The first bit of a word follows the last bit of the previous word.
  // Without a previous word, leave that candidate untouched.
  assign mask[WORD_W-1] = prev_ok ? (cur[WORD_W-1] ^ prev_lsb) : 1'b1;
endmodule

// File: rtl/align_realign.sv
module align_realign
  import align_pkg::*;
(
  input  word_t prev,
  input  word_t cur,
  input  pos_t  pos,
  output pay_t  data,
  output logic  ctrl,
  output logic  hdr_bad
);
  localparam int CAT_W = 2 * WORD_W;

  logic [CAT_W-1:0] cat;
  pos_t             shamt;
  word_t            aligned;

  // The saved change position sits at the second header bit; the rotation
  // is two past it, modulo the word width.
  always_comb begin
    if (pos >= pos_t'(WORD_W - 2)) shamt = pos - pos_t'(WORD_W - 2);
    else                           shamt = pos + pos_t'(2);
  end

  assign cat     = {prev, cur};
  assign aligned = WORD_W'(cat >> shamt);

  assign data    = aligned[PAY_W-1:0] ^ {PAY_W{aligned[INV_BIT]}};
  assign ctrl    = ({aligned[HDR_HI], aligned[HDR_LO]} == HDR_CTRL);
  assign hdr_bad = (aligned[HDR_HI] == aligned[HDR_LO]);
endmodule

// File: rtl/align_lock_ctrl.sv
module align_lock_ctrl
  import align_pkg::*;
#(
  parameter int LOCK_WORDS = 64,
  parameter int WINDOW     = 64,
  parameter int ERR_LIMIT  = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  word_t mask,
  input  logic  hdr_bad,
  output logic  locked,
  output pos_t  pos
);
  localparam int CNT_W = $clog2(LOCK_WORDS + 1);
  localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam int ERR_W = $clog2(ERR_LIMIT + 2);

  word_t            cand, narrowed;
  logic [CNT_W-1:0] hits, hits_inc;
  logic [WIN_W-1:0] win;
  logic [ERR_W-1:0] errs, errs_sum;
  logic             none, single, reach, over, win_last;
  pos_t             enc;

  always_comb begin
    narrowed = cand & mask;
    none     = (narrowed == '0);
    single   = !none && ((narrowed & (narrowed - word_t'(1))) == '0);
    hits_inc = (hits == CNT_W'(LOCK_WORDS)) ? hits : hits + CNT_W'(1);
    reach    = (hits_inc >= CNT_W'(LOCK_WORDS));
    enc      = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (narrowed[i]) enc = pos_t'(i);
    end
    errs_sum = errs + ERR_W'(hdr_bad);
    over     = (errs_sum > ERR_W'(ERR_LIMIT));
    win_last = (win == WIN_W'(WINDOW - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand   <= '1;
      hits   <= '0;
      locked <= 1'b0;
      pos    <= '0;
      win    <= '0;
      errs   <= '0;
    end else if (step) begin
      if (!locked) begin
        if (none) begin
          cand <= '1;
          hits <= '0;
        end else if (single && reach) begin
          locked <= 1'b1;
          pos    <= enc;
          cand   <= '1;
          hits   <= '0;
          win    <= '0;
          errs   <= '0;
        end else begin
          cand <= narrowed;
          hits <= hits_inc;
        end
      end else begin
        if (over) begin
          locked <= 1'b0;
          win    <= '0;
          errs   <= '0;
        end else if (win_last) begin
          win  <= '0;
          errs <= '0;
        end else begin
          win  <= win + WIN_W'(1);
          errs <= errs_sum;
        end
      end
    end
  end
endmodule

// File: rtl/word_align_dec.sv
module word_align_dec
  import align_pkg::*;
#(
  parameter int LOCK_WORDS = 64,
  parameter int WINDOW     = 64,
  parameter int ERR_LIMIT  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [66:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic        out_ctrl,
  output logic        out_hdr_err,
  output logic        lock
);
  word_t prev_word;
  logic  prev_ok;
  word_t mask;
  pos_t  pos;
  pay_t  al_data;
  logic  al_ctrl, al_bad, locked, accept;

  assign in_ready = out_ready || !out_valid;
  assign accept   = in_valid && in_ready;
  assign lock     = locked;

  align_trans_mask u_mask (
    .cur      (in_word),
    .prev_lsb (prev_word[0]),
    .prev_ok  (prev_ok),
    .mask     (mask)
  );

  align_realign u_realign (
    .prev    (prev_word),
    .cur     (in_word),
    .pos     (pos),
    .data    (al_data),
    .ctrl    (al_ctrl),
    .hdr_bad (al_bad)
  );

  align_lock_ctrl #(
    .LOCK_WORDS (LOCK_WORDS),
    .WINDOW     (WINDOW),
    .ERR_LIMIT  (ERR_LIMIT)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (accept),
    .mask    (mask),
    .hdr_bad (al_bad),
    .locked  (locked),
    .pos     (pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_word <= '0;
      prev_ok   <= 1'b0;
    end else if (accept) begin
      prev_word <= in_word;
      prev_ok   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_ctrl    <= 1'b0;
      out_hdr_err <= 1'b0;
    end else if (in_ready) begin
      out_valid <= accept && locked;
      if (accept && locked) begin
        out_data    <= al_data;
        out_ctrl    <= al_ctrl;
        out_hdr_err <= al_bad;
      end
    end
  end
endmodule

// File: rtl/word_align_dec_chk.sv
module word_align_dec_chk #(
  parameter int LOCK_WORDS = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_ctrl,
  input logic        out_hdr_err,
  input logic        lock
);
  localparam int SEEN_W = $clog2(LOCK_WORDS + 1);
  logic [SEEN_W-1:0] seen;

  // Words taken since reset or since lock was dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen <= '0;
    else if (lock)              seen <= '0;
    else if (in_valid && in_ready && seen < SEEN_W'(LOCK_WORDS))
      seen <= seen + SEEN_W'(1);
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_r1: assert (!out_valid && !lock);
    end
  end

  p_lock_after_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> seen >= SEEN_W'(LOCK_WORDS));

  p_quiet_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !lock) |=> !out_valid);

  p_unlock_on_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> (out_valid && out_hdr_err));

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_ctrl) && $stable(out_hdr_err)));
endmodule

bind word_align_dec word_align_dec_chk #(.LOCK_WORDS(LOCK_WORDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_ctrl    (out_ctrl),
  .out_hdr_err (out_hdr_err),
  .lock        (lock)
);

// File: tb/tb_word_align_dec.sv
`timescale 1ns/1ps
module tb_word_align_dec;
  localparam int LOCK_N = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [66:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;
  logic        out_ctrl;
  logic        out_hdr_err;
  logic        lock;

  always #5 clk = ~clk;

  word_align_dec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ctrl(out_ctrl), .out_hdr_err(out_hdr_err),
    .lock(lock)
  );

  int checks = 0;
  int errors = 0;
  bit bad [8192];
  int rot = 0;
  int unsigned p = 0;
  int unsigned base = 16;
  int unsigned exp_q = 0;
  bit armed = 1'b0;
  int outs = 0, err_seen = 0, ctrl_seen = 0, inv_seen = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input int unsigned q);
    logic [63:0] h;
    h = 64'(q) * 64'h9E3779B97F4A7C15;
    h = h ^ (h >> 29);
    h = h * 64'hBF58476D1CE4E5B9;
    return h ^ (h >> 31);
  endfunction

  // Aligned word q: header in 66:65, inversion flag in 64, payload below.
  function automatic logic [66:0] make_word(input int unsigned q);
    logic [63:0] pay;
    logic [1:0]  hdr;
    logic        inv;
    pay = mix(q);
    inv = pay[7];
    hdr = bad[q % 8192] ? 2'b00 : (pay[3] ? 2'b10 : 2'b01);
    return {hdr, inv, inv ? ~pay : pay};
  endfunction

  function automatic logic [66:0] rx_word(input int unsigned q);
    logic [133:0] c;
    c = {make_word(q), make_word(q + 1)} << rot;
    return c[133:67];
  endfunction

  // Output monitor: checks every word taken downstream.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      outs++;
      if (!armed) begin
        chk(1'b0, "R4", "output while unlocked", 64'(out_valid), 64'd0);
      end else begin
        logic [66:0] e;
        logic [63:0] pay;
        e   = make_word(exp_q);
        pay = e[64] ? ~e[63:0] : e[63:0];
        chk(out_data == pay, "R5", "realigned payload", out_data, pay);
        chk(out_ctrl == (e[66:65] == 2'b10), "R6", "control flag",
            64'(out_ctrl), 64'(e[66:65] == 2'b10));
        chk(out_hdr_err == (e[66] == e[65]), "R7", "header error flag",
            64'(out_hdr_err), 64'(e[66] == e[65]));
        if (out_hdr_err) err_seen++;
        if (out_ctrl) ctrl_seen++;
        if (e[64]) inv_seen++;
        exp_q++;
        if (!lock) armed = 1'b0;
      end
    end
  end

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic send_word(input logic [66:0] w);
    @(negedge clk);
    while (!in_ready) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_run(input int n);
    for (int i = 0; i < n; i++) begin
      send_word(rx_word(p));
      p++;
    end
  endtask

  task automatic do_reset(input int r);
    rot = r;
    armed = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    out_ready = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    p = base;
    base += 1000;
  endtask

  task automatic acquire(input string tag);
    int o0;
    o0 = outs;
    send_run(LOCK_N - 1);
    settle();
    chk(lock == 1'b0, "R2", {tag, " lock before 64th word"}, 64'(lock), 64'd0);
    send_run(1);
    settle();
    chk(lock == 1'b1, "R2", {tag, " lock on 64th word"}, 64'(lock), 64'd1);
    chk(outs == o0, "R4", {tag, " no output during search"}, 64'(outs), 64'(o0));
    exp_q = p;
    armed = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(0);
    settle();
    chk(lock == 1'b0, "R1", "lock after reset", 64'(lock), 64'd0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_rotation(input int r);
    int o0, c0, i0;
    do_reset(r);
    acquire($sformatf("rot %0d", r));
    o0 = outs; c0 = ctrl_seen; i0 = inv_seen;
    send_run(80);
    settle();
    chk(outs == o0 + 80, "R4", "one output per locked word", 64'(outs), 64'(o0 + 80));
    chk(ctrl_seen > c0 && ctrl_seen < c0 + 80, "R6", "mix of control and data words",
        64'(ctrl_seen - c0), 64'd40);
    chk(inv_seen > i0, "R6", "inverted words restored", 64'(inv_seen - i0), 64'd1);
  endtask

  task automatic t_no_header();
    int o0;
    do_reset(11);
    o0 = outs;
    for (int i = 0; i < 300; i++) begin
      send_word({mix(p + 777777)[2:0], mix(p)});
      p++;
    end
    settle();
    chk(lock == 1'b0, "R3", "no lock without recurring change", 64'(lock), 64'd0);
    chk(outs == o0, "R3", "no output without lock", 64'(outs), 64'(o0));
  endtask

  task automatic t_budget();
    int unsigned w0;
    int e0;
    do_reset(23);
    w0 = p + LOCK_N;
    for (int k = 48;  k < 80;  k++) bad[(w0 + k) % 8192] = 1'b1;
    for (int k = 133; k < 150; k++) bad[(w0 + k) % 8192] = 1'b1;
    e0 = err_seen;
    acquire("budget");
    send_run(64);
    settle();
    chk(lock == 1'b1, "R8", "16 errors in one window keep lock", 64'(lock), 64'd1);
    send_run(64);
    settle();
    chk(lock == 1'b1, "R8", "count restarts at window edge", 64'(lock), 64'd1);
    send_run(21);
    settle();
    chk(lock == 1'b1, "R8", "16th error of window keeps lock", 64'(lock), 64'd1);
    send_run(1);
    settle();
    chk(lock == 1'b0, "R9", "17th error drops lock", 64'(lock), 64'd0);
    chk(err_seen == e0 + 49, "R7", "header errors flagged", 64'(err_seen - e0), 64'd49);
    chk(armed == 1'b0, "R9", "losing word still output", 64'(armed), 64'd0);
    acquire("relock");
    send_run(5);
    settle();
  endtask

  task automatic t_backpressure();
    int o0;
    logic [63:0] held;
    do_reset(5);
    acquire("stall");
    o0 = outs;
    send_run(10);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_word   = rx_word(p);
    held      = out_data;
    for (int i = 0; i < 5; i++) begin
      settle();
      chk(out_valid == 1'b1 && out_data == held, "R10", "output held in stall",
          out_data, held);
      chk(in_ready == 1'b0, "R10", "input refused in stall", 64'(in_ready), 64'd0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b0;
    send_run(10);
    settle();
    chk(outs == o0 + 20, "R10", "no loss or repeat across stall", 64'(outs), 64'(o0 + 20));
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    out_ready = 1'b1;
    t_reset();
    t_rotation(0);
    t_rotation(1);
    t_rotation(37);
    t_rotation(66);
    t_no_header();
    t_budget();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule